// File: doc/BRIEF.md
# Ordered Miss-Coalescing Fill Buffers

This block sits between the commit end of a store buffer and the L1 data cache. A store at the head of the store buffer that misses in L1 does not have to wait there for its read-for-ownership (RFO) to finish. It can leave into a small pool of line fill buffers. Each buffer collects the bytes written to one cache line, asks the memory side for ownership of that line once, merges the fetched line around the stored bytes, and writes the full line into L1. When that write is accepted, L1 installs the line in the Modified state.

Two rules keep store-to-store order. A store may join only the most recently opened buffer. The buffers write to L1 strictly in the order they were opened. A store aimed at a line that an older buffer holds therefore stays in the store buffer (the A-B-A case). A store that hits in L1 is held back while any miss buffer is occupied, so it cannot become visible ahead of an older miss. Buffer slots are reused as a ring, so the order in which buffers are opened is also the order in which they are written to L1.

The pool size must be a power of two, at least 2. A store carries a line address, an 8-byte word index within the 64-byte line, 64 data bits and 8 byte enables.

Top module: `ordered_fill_buffers`

## Requirements
- R1: A store that misses, with no occupied buffer holding its line and a free buffer available, is accepted and opens a buffer. Exactly one RFO is then requested for that line. Pending RFOs are offered oldest buffer first. An offered RFO holds its line and id stable until `rfo_ready_i` is seen.
- R2: A missing store to the line of the most recently opened buffer is accepted and merged into it. The run AAABBCCCC is accepted without stalls and issues three RFOs.
- R3: A missing store to a line held by an occupied buffer that is not the most recently opened one is stalled (ready low). It stays stalled until that buffer has written to L1. In A,B,A the final A stalls.
- R4: Buffers write to L1 in the order they were opened. A younger buffer whose fill arrives first waits for every older buffer.
- R5: Store word index w with byte enable bit k writes line byte 8w+k, taken from data bits [8k+7:8k]. The line written to L1 holds the stored bytes, with the latest store winning. Every byte not written by a store comes from the fill data, where line byte b is at bits [8b+7:8b].
- R6: A store flagged as an L1 hit is accepted only when no buffer is occupied.
- R7: When every buffer is occupied, a missing store to a line held by no buffer is stalled.
- R8: A line write to L1 holds its valid, line and data stable until `l1_wr_ready_i`. The buffer is freed in that cycle. A missing store to the line of a buffer that is currently offering its write is stalled in that cycle.
- R9: After reset no RFO and no L1 write is offered, and a missing store is ready to be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store present at the store-buffer head |
| st_hit_i | input | 1 | The store's line is owned in L1 |
| st_line_i | input | LINE_AW | Line address of the store |
| st_word_i | input | log2(LINE_BYTES/WORD_BYTES) | Word index within the line |
| st_data_i | input | 8*WORD_BYTES | Store data |
| st_be_i | input | WORD_BYTES | Byte enables of the store |
| st_ready_o | output | 1 | Store accepted this cycle (low means stall) |
| rfo_valid_o | output | 1 | RFO request offered |
| rfo_ready_i | input | 1 | RFO request taken |
| rfo_line_o | output | LINE_AW | Line address to request ownership of |
| rfo_id_o | output | log2(NUM_BUF) | Buffer id to return with the fill |
| fill_valid_i | input | 1 | RFO response with line data |
| fill_id_i | input | log2(NUM_BUF) | Buffer id of the response |
| fill_data_i | input | 8*LINE_BYTES | Owned line contents |
| l1_wr_valid_o | output | 1 | Full-line write to L1 offered |
| l1_wr_ready_i | input | 1 | L1 accepts the line write |
| l1_wr_line_o | output | LINE_AW | Line address written |
| l1_wr_data_o | output | 8*LINE_BYTES | Merged line data written |

## Verification
The bench builds the block with four buffers, 64-byte lines and 8-byte store words. With only four buffers, full-pool stalls are easy to reach, and a pool of eight line addresses keeps producing A-B-A conflicts. Fills are returned either at random or youngest first, so younger buffers regularly complete before older ones and must wait for in-order commit. Withholding L1 write acceptance exposes the hold-stable rule and the stall on a line that is mid-write.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [1:0] {
    FB_FREE = 2'd0,
    FB_REQ  = 2'd1,  // opened, RFO not yet sent
    FB_WAIT = 2'd2,  // RFO sent, waiting for line
    FB_FULL = 2'd3   // line present, ready to write L1
  } fb_state_e;
endpackage

// File: rtl/fb_slot.sv
module fb_slot
  import fb_pkg::*;
#(
  parameter int LINE_AW    = 26,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int WOFF_W     = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_i,
  input  logic [LINE_AW-1:0]      line_i,
  input  logic                    wr_i,
  input  logic [WOFF_W-1:0]       word_i,
  input  logic [8*WORD_BYTES-1:0] data_i,
  input  logic [WORD_BYTES-1:0]   be_i,
  input  logic                    sent_i,
  input  logic                    fill_i,
  input  logic [8*LINE_BYTES-1:0] fill_data_i,
  input  logic                    free_i,
  output fb_state_e               state_o,
  output logic [LINE_AW-1:0]      line_o,
  output logic [8*LINE_BYTES-1:0] data_o
);
  localparam int WORDS = LINE_BYTES / WORD_BYTES;

  fb_state_e               state_q;
  logic [LINE_AW-1:0]      line_q;
  logic [LINE_BYTES-1:0]   mask_q, mask_d, mask_base;
  logic [8*LINE_BYTES-1:0] data_q, data_d;

  // store bytes beat earlier bytes; fill only lands on bytes never stored
  always_comb begin
    mask_base = alloc_i ? '0 : mask_q;
    mask_d    = mask_base;
    data_d    = data_q;
    for (int w = 0; w < WORDS; w++) begin
      for (int k = 0; k < WORD_BYTES; k++) begin
        if (wr_i && (WOFF_W'(w) == word_i) && be_i[k]) begin
          mask_d[w*WORD_BYTES+k]            = 1'b1;
          data_d[8*(w*WORD_BYTES+k) +: 8]   = data_i[8*k +: 8];
        end else if (fill_i && !mask_base[w*WORD_BYTES+k]) begin
          data_d[8*(w*WORD_BYTES+k) +: 8]   = fill_data_i[8*(w*WORD_BYTES+k) +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FB_FREE;
      line_q  <= '0;
      mask_q  <= '0;
    end else begin
      mask_q <= mask_d;
      if (alloc_i) line_q <= line_i;
      if (free_i)       state_q <= FB_FREE;
      else if (alloc_i) state_q <= FB_REQ;
      else if (sent_i)  state_q <= FB_WAIT;
      else if (fill_i)  state_q <= FB_FULL;
    end
  end

  always_ff @(posedge clk_i) data_q <= data_d;

  assign state_o = state_q;
  assign line_o  = line_q;
  assign data_o  = data_q;
endmodule

// File: rtl/fb_ring.sv
module fb_ring #(
  parameter int NUM_BUF = 4,
  parameter int IW      = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [IW-1:0] head_o,
  output logic [IW-1:0] tail_o,
  output logic [IW-1:0] young_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [IW-1:0] head_q, tail_q;
  logic [IW:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop_i)  head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + {{IW{1'b0}}, push_i} - {{IW{1'b0}}, pop_i};
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign young_o = tail_q - 1'b1;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (IW+1)'(NUM_BUF));
endmodule

// File: rtl/fb_admit.sv
module fb_admit #(
  parameter int NUM_BUF = 4,
  parameter int IW      = 2,
  parameter int LINE_AW = 26
) (
  input  logic                            st_valid_i,
  input  logic                            st_hit_i,
  input  logic [LINE_AW-1:0]              st_line_i,
  input  logic [NUM_BUF-1:0][LINE_AW-1:0] lines_i,
  input  logic [NUM_BUF-1:0]              occ_i,
  input  logic [IW-1:0]                   young_i,
  input  logic [IW-1:0]                   head_i,
  input  logic                            head_wr_i,
  input  logic                            empty_i,
  input  logic                            full_i,
  output logic                            ready_o,
  output logic                            alloc_o,
  output logic                            merge_o
);
  logic [NUM_BUF-1:0] match;
  logic               any_match;

  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) match[i] = occ_i[i] && (lines_i[i] == st_line_i);
  end
  assign any_match = |match;

  always_comb begin
    if (st_hit_i)       ready_o = empty_i;
    else if (any_match) ready_o = match[young_i] && !((young_i == head_i) && head_wr_i);
    else                ready_o = !full_i;
  end

  assign merge_o = st_valid_i && !st_hit_i && any_match && ready_o;
  assign alloc_o = st_valid_i && !st_hit_i && !any_match && ready_o;
endmodule

// File: rtl/ordered_fill_buffers.sv
module ordered_fill_buffers
  import fb_pkg::*;
#(
  parameter int NUM_BUF    = 4,
  parameter int LINE_AW    = 26,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       st_valid_i,
  input  logic                                       st_hit_i,
  input  logic [LINE_AW-1:0]                         st_line_i,
  input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0]   st_word_i,
  input  logic [8*WORD_BYTES-1:0]                    st_data_i,
  input  logic [WORD_BYTES-1:0]                      st_be_i,
  output logic                                       st_ready_o,
  output logic                                       rfo_valid_o,
  input  logic                                       rfo_ready_i,
  output logic [LINE_AW-1:0]                         rfo_line_o,
  output logic [$clog2(NUM_BUF)-1:0]                 rfo_id_o,
  input  logic                                       fill_valid_i,
  input  logic [$clog2(NUM_BUF)-1:0]                 fill_id_i,
  input  logic [8*LINE_BYTES-1:0]                    fill_data_i,
  output logic                                       l1_wr_valid_o,
  input  logic                                       l1_wr_ready_i,
  output logic [LINE_AW-1:0]                         l1_wr_line_o,
  output logic [8*LINE_BYTES-1:0]                    l1_wr_data_o
);
  localparam int IW     = $clog2(NUM_BUF);
  localparam int WOFF_W = $clog2(LINE_BYTES / WORD_BYTES);

  fb_state_e                           state_w [NUM_BUF];
  logic [NUM_BUF-1:0][LINE_AW-1:0]     lines_w;
  logic [NUM_BUF-1:0][8*LINE_BYTES-1:0] data_w;
  logic [NUM_BUF-1:0]                  occ;
  logic [IW-1:0]                       head, tail, young;
  logic                                empty, full;
  logic                                do_alloc, do_merge, do_free;

  fb_ring #(.NUM_BUF(NUM_BUF), .IW(IW)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (do_alloc),
    .pop_i   (do_free),
    .head_o  (head),
    .tail_o  (tail),
    .young_o (young),
    .empty_o (empty),
    .full_o  (full)
  );

  fb_admit #(.NUM_BUF(NUM_BUF), .IW(IW), .LINE_AW(LINE_AW)) u_admit (
    .st_valid_i (st_valid_i),
    .st_hit_i   (st_hit_i),
    .st_line_i  (st_line_i),
    .lines_i    (lines_w),
    .occ_i      (occ),
    .young_i    (young),
    .head_i     (head),
    .head_wr_i  (l1_wr_valid_o),
    .empty_i    (empty),
    .full_i     (full),
    .ready_o    (st_ready_o),
    .alloc_o    (do_alloc),
    .merge_o    (do_merge)
  );

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
    logic alloc_s, wr_s, sent_s, fill_s, free_s;
    assign alloc_s = do_alloc && (tail == IW'(i));
    assign wr_s    = alloc_s || (do_merge && (young == IW'(i)));
    assign sent_s  = rfo_valid_o && rfo_ready_i && (rfo_id_o == IW'(i));
    assign fill_s  = fill_valid_i && (fill_id_i == IW'(i)) && (state_w[i] == FB_WAIT);
    assign free_s  = do_free && (head == IW'(i));
    assign occ[i]  = (state_w[i] != FB_FREE);

    fb_slot #(
      .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES),
      .WORD_BYTES(WORD_BYTES), .WOFF_W(WOFF_W)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_s),
      .line_i      (st_line_i),
      .wr_i        (wr_s),
      .word_i      (st_word_i),
      .data_i      (st_data_i),
      .be_i        (st_be_i),
      .sent_i      (sent_s),
      .fill_i      (fill_s),
      .fill_data_i (fill_data_i),
      .free_i      (free_s),
      .state_o     (state_w[i]),
      .line_o      (lines_w[i]),
      .data_o      (data_w[i])
    );
  end

  // oldest buffer still needing its RFO goes first
  always_comb begin
    rfo_valid_o = 1'b0;
    rfo_id_o    = head;
    for (int k = 0; k < NUM_BUF; k++) begin
      if (!rfo_valid_o && (state_w[IW'(head + IW'(k))] == FB_REQ)) begin
        rfo_valid_o = 1'b1;
        rfo_id_o    = IW'(head + IW'(k));
      end
    end
  end
  assign rfo_line_o = lines_w[rfo_id_o];

  assign l1_wr_valid_o = !empty && (state_w[head] == FB_FULL);
  assign l1_wr_line_o  = lines_w[head];
  assign l1_wr_data_o  = data_w[head];
  assign do_free       = l1_wr_valid_o && l1_wr_ready_i;
endmodule

// File: rtl/fb_order_chk.sv
module fb_order_chk #(
  parameter int NUM_BUF    = 4,
  parameter int LINE_AW    = 26,
  parameter int LINE_BYTES = 64
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    st_valid_i,
  input logic                    st_hit_i,
  input logic                    st_ready_o,
  input logic                    rfo_valid_o,
  input logic                    rfo_ready_i,
  input logic [LINE_AW-1:0]      rfo_line_o,
  input logic [$clog2(NUM_BUF)-1:0] rfo_id_o,
  input logic                    l1_wr_valid_o,
  input logic                    l1_wr_ready_i,
  input logic [LINE_AW-1:0]      l1_wr_line_o,
  input logic [8*LINE_BYTES-1:0] l1_wr_data_o
);
  localparam int IW = $clog2(NUM_BUF);

  // lines in the order their RFOs left; commits must follow it
  logic [LINE_AW-1:0] rec_q [NUM_BUF];
  logic [IW-1:0]      wp_q, rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
      for (int i = 0; i < NUM_BUF; i++) rec_q[i] <= '0;
    end else begin
      if (rfo_valid_o && rfo_ready_i) begin
        rec_q[wp_q] <= rfo_line_o;
        wp_q        <= wp_q + 1'b1;
      end
      if (l1_wr_valid_o && l1_wr_ready_i) rp_q <= rp_q + 1'b1;
    end
  end

  p_commit_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_wr_valid_o |-> (l1_wr_line_o == rec_q[rp_q]));

  p_wr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_wr_valid_o && !l1_wr_ready_i) |=>
      (l1_wr_valid_o && $stable(l1_wr_line_o) && $stable(l1_wr_data_o)));

  p_rfo_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfo_valid_o && !rfo_ready_i) |=>
      (rfo_valid_o && $stable(rfo_line_o) && $stable(rfo_id_o)));

  p_hit_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && st_hit_i && (rfo_valid_o || l1_wr_valid_o)) |-> !st_ready_o);
endmodule

bind ordered_fill_buffers fb_order_chk #(
  .NUM_BUF(NUM_BUF), .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .st_valid_i    (st_valid_i),
  .st_hit_i      (st_hit_i),
  .st_ready_o    (st_ready_o),
  .rfo_valid_o   (rfo_valid_o),
  .rfo_ready_i   (rfo_ready_i),
  .rfo_line_o    (rfo_line_o),
  .rfo_id_o      (rfo_id_o),
  .l1_wr_valid_o (l1_wr_valid_o),
  .l1_wr_ready_i (l1_wr_ready_i),
  .l1_wr_line_o  (l1_wr_line_o),
  .l1_wr_data_o  (l1_wr_data_o)
);

// File: tb/sim_ordered_fill_buffers.sv
module sim_ordered_fill_buffers;
  localparam int NB  = 4;
  localparam int LAW = 26;
  localparam int LB  = 64;
  localparam int WB  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              st_valid, st_hit, st_ready;
  logic [LAW-1:0]    st_line;
  logic [2:0]        st_word;
  logic [8*WB-1:0]   st_data;
  logic [WB-1:0]     st_be;
  logic              rfo_valid, rfo_ready;
  logic [LAW-1:0]    rfo_line;
  logic [1:0]        rfo_id;
  logic              fill_valid;
  logic [1:0]        fill_id;
  logic [8*LB-1:0]   fill_data;
  logic              wr_valid, wr_ready;
  logic [LAW-1:0]    wr_line;
  logic [8*LB-1:0]   wr_data;

  ordered_fill_buffers #(.NUM_BUF(NB), .LINE_AW(LAW), .LINE_BYTES(LB), .WORD_BYTES(WB)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_hit_i(st_hit), .st_line_i(st_line), .st_word_i(st_word),
    .st_data_i(st_data), .st_be_i(st_be), .st_ready_o(st_ready),
    .rfo_valid_o(rfo_valid), .rfo_ready_i(rfo_ready), .rfo_line_o(rfo_line), .rfo_id_o(rfo_id),
    .fill_valid_i(fill_valid), .fill_id_i(fill_id), .fill_data_i(fill_data),
    .l1_wr_valid_o(wr_valid), .l1_wr_ready_i(wr_ready), .l1_wr_line_o(wr_line),
    .l1_wr_data_o(wr_data)
  );

  int n_cmp = 0, n_bad = 0, rfo_seen = 0;
  bit done = 0;

  typedef struct {
    logic [LAW-1:0]  line;
    logic [LB-1:0]   mask;
    logic [8*LB-1:0] d;
    int              st;   // 0 needs RFO, 1 waiting, 2 filled
    int              id;
  } ent_t;
  typedef struct {
    logic [LAW-1:0] line;
    logic [2:0]     w;
    logic [63:0]    d;
    logic [7:0]     be;
    logic           hit;
  } sto_t;

  ent_t mq[$];
  sto_t pend[$];

  function automatic logic [8*LB-1:0] line_fill(logic [LAW-1:0] l);
    logic [8*LB-1:0] r;
    for (int b = 0; b < LB; b++) r[8*b +: 8] = 8'(int'(l) * 7 + b * 13 + 5);
    return r;
  endfunction

  task automatic chk(string rq, string what, logic [8*LB-1:0] act, logic [8*LB-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(logic [LAW-1:0] l, logic [2:0] w, logic [63:0] d, logic [7:0] be, logic h);
    sto_t s;
    s.line = l; s.w = w; s.d = d; s.be = be; s.hit = h;
    pend.push_back(s);
  endtask

  // fmode 0: random waiting buffer, 1: youngest waiting buffer first
  task automatic step(int pf, int pr, int pw, int fmode);
    int j, e_rfo, fk, last;
    bit e_ready, e_wr, in_q;
    string tag;
    int waits[$];
    @(negedge clk);
    in_q = 0;
    if (pend.size() > 0) foreach (mq[i]) if (mq[i].line == pend[0].line) in_q = 1;
    st_valid = (pend.size() > 0);
    st_line  = st_valid ? pend[0].line : '0;
    st_word  = st_valid ? pend[0].w : '0;
    st_data  = st_valid ? pend[0].d : '0;
    st_be    = st_valid ? pend[0].be : '0;
    st_hit   = st_valid && pend[0].hit && !in_q;
    rfo_ready = ($urandom % 100) < pr;
    wr_ready  = ($urandom % 100) < pw;
    foreach (mq[i]) if (mq[i].st == 1) waits.push_back(i);
    fk = -1;
    if (waits.size() > 0 && ($urandom % 100) < pf)
      fk = (fmode == 1) ? waits[waits.size()-1] : waits[$urandom % waits.size()];
    fill_valid = (fk >= 0);
    fill_id    = (fk >= 0) ? 2'(mq[fk].id) : '0;
    fill_data  = (fk >= 0) ? line_fill(mq[fk].line) : '0;
    #1;
    // expected decisions from the requirements
    j = -1;
    foreach (mq[i]) if (mq[i].line == st_line) j = i;
    last = mq.size() - 1;
    if (st_hit) begin e_ready = (mq.size() == 0); tag = "R6"; end
    else if (j >= 0) begin
      if (j != last) begin e_ready = 0; tag = "R3"; end
      else if (j == 0 && mq[0].st == 2) begin e_ready = 0; tag = "R8"; end
      else begin e_ready = 1; tag = "R2"; end
    end else begin
      e_ready = (mq.size() < NB);
      tag = e_ready ? "R1" : "R7";
    end
    e_rfo = -1;
    foreach (mq[i]) if (e_rfo < 0 && mq[i].st == 0) e_rfo = i;
    e_wr = (mq.size() > 0) && (mq[0].st == 2);
    if (st_valid) chk(tag, "st_ready", 512'(st_ready), 512'(e_ready));
    chk("R1", "rfo_valid", 512'(rfo_valid), 512'(e_rfo >= 0));
    if (e_rfo >= 0 && rfo_valid) chk("R1", "rfo_line", 512'(rfo_line), 512'(mq[e_rfo].line));
    chk("R4", "wr_valid", 512'(wr_valid), 512'(e_wr));
    if (e_wr && wr_valid) begin
      chk("R4", "wr_line", 512'(wr_line), 512'(mq[0].line));
      chk("R5", "wr_data", wr_data, mq[0].d);
    end
    if (rfo_valid && rfo_ready) rfo_seen++;
    // advance the model
    if (fk >= 0) begin
      for (int b = 0; b < LB; b++) if (!mq[fk].mask[b]) mq[fk].d[8*b +: 8] = fill_data[8*b +: 8];
      mq[fk].st = 2;
    end
    if (e_rfo >= 0 && rfo_ready) begin mq[e_rfo].st = 1; mq[e_rfo].id = int'(rfo_id); end
    if (st_valid && e_ready) begin
      if (!st_hit) begin
        if (j < 0) begin
          ent_t n;
          n.line = st_line; n.mask = '0; n.d = '0; n.st = 0; n.id = -1;
          mq.push_back(n);
        end
        last = mq.size() - 1;
        for (int k = 0; k < WB; k++) if (st_be[k]) begin
          mq[last].mask[8*st_word + k] = 1'b1;
          mq[last].d[8*(8*st_word + k) +: 8] = st_data[8*k +: 8];
        end
      end
      void'(pend.pop_front());
    end
    if (e_wr && wr_ready) void'(mq.pop_front());
  endtask

  task automatic drain(int fmode);
    for (int n = 0; n < 300 && (mq.size() > 0 || pend.size() > 0); n++) step(100, 100, 100, fmode);
  endtask

  initial begin
    rst_n = 0; st_valid = 0; st_hit = 0; st_line = '0; st_word = '0; st_data = '0; st_be = '0;
    rfo_ready = 0; fill_valid = 0; fill_id = '0; fill_data = '0; wr_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R9", "rfo_valid after reset", 512'(rfo_valid), 512'(0));
    chk("R9", "wr_valid after reset", 512'(wr_valid), 512'(0));
    chk("R9", "st_ready after reset", 512'(st_ready), 512'(1));

    // R2: AAABBCCCC merges into three buffers
    for (int i = 0; i < 3; i++) push(26'h100, 3'(i), 64'h1111_0000 + 64'(i), 8'hff, 0);
    for (int i = 0; i < 2; i++) push(26'h200, 3'(i+4), 64'h2222_0000 + 64'(i), 8'h0f, 0);
    for (int i = 0; i < 4; i++) push(26'h300, 3'(i*2), 64'h3333_0000 + 64'(i), 8'hf0, 0);
    rfo_seen = 0;
    repeat (14) step(0, 100, 100, 0);
    chk("R2", "RFOs for AAABBCCCC", 512'(rfo_seen), 512'(3));
    chk("R2", "stores left after run", 512'(pend.size()), 512'(0));
    drain(0);

    // R3: A,B,A stalls on the last A
    push(26'h40, 0, 64'hA1, 8'h01, 0);
    push(26'h41, 1, 64'hB1, 8'h01, 0);
    push(26'h40, 2, 64'hA2, 8'h01, 0);
    push(26'h42, 3, 64'hC1, 8'h01, 0);
    repeat (8) step(0, 100, 100, 0);
    chk("R3", "stalled stores in A,B,A", 512'(pend.size()), 512'(2));
    drain(0);

    // R4: fills return youngest first, writes stay in order
    push(26'h50, 0, 64'h5, 8'h03, 0);
    push(26'h51, 1, 64'h6, 8'h0c, 0);
    push(26'h52, 7, 64'h7, 8'h80, 0);
    repeat (6) step(0, 100, 100, 0);
    drain(1);

    // R7: pool full
    for (int i = 0; i < 6; i++) push(26'h60 + 26'(i), 3'(i), 64'(i), 8'hff, 0);
    repeat (10) step(0, 100, 100, 0);
    chk("R7", "stores held with full pool", 512'(pend.size()), 512'(2));
    drain(0);

    // R6: hit store waits behind a miss
    push(26'h70, 0, 64'h77, 8'hff, 0);
    push(26'h71, 0, 64'h88, 8'hff, 1);
    repeat (6) step(0, 100, 100, 0);
    chk("R6", "hit store held", 512'(pend.size()), 512'(1));
    drain(0);

    // R8: L1 withholds acceptance, then a same-line store arrives
    push(26'h80, 1, 64'h99, 8'hff, 0);
    repeat (4) step(100, 100, 0, 0);
    push(26'h80, 2, 64'haa, 8'hff, 0);
    repeat (4) step(0, 100, 0, 0);
    chk("R8", "same-line store held during write", 512'(pend.size()), 512'(1));
    drain(0);

    // mixed traffic over a small line pool
    for (int n = 0; n < 4000; n++) begin
      if (pend.size() < 2)
        push(26'h900 + 26'($urandom % 8), 3'($urandom), {$urandom, $urandom}, 8'($urandom),
             ($urandom % 5) == 0);
      step(30, 60, 60, int'($urandom % 2));
    end
    drain(0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule